// File: doc/BRIEF.md
# Closed Caption Byte Acquisition

This block pulls the two caption bytes carried once per field on one chosen video line of 525-line timing. A slicer upstream delivers the line as a stream of NRZ bits, each marked by a one-cycle strobe, together with a pulse at the start of every line and a pulse at the start of every field. The block counts lines from the field pulse. When the counted line equals the programmed capture line, it zeroes both data registers. It then waits for a clock run-in followed by the start pattern and shifts the next sixteen bits into the two registers.

When the capture line ends, either at the next line pulse or at a field pulse, the block emits a one-cycle interrupt pulse if its interrupt enable is set. The same event latches a pending flag, which software clears by writing 0. All of this happens only while the acquisition enable is high. Software reads the two bytes and decodes the caption content itself.

Top module: `cc_acq`

## Requirements
- R1: After reset the line-select register reads 21, both data registers read 00h, and the interrupt and pending outputs are 0.
- R2: The line count is 0 after a field pulse, and each line pulse adds one, so the first line of a field is line 1. Capture happens only on the line whose number equals the line-select register. Caption waveforms on any other line leave the data registers unchanged.
- R3: Both data registers become 00h in the cycle after the line pulse that opens the selected line.
- R4: After synchronisation, the 1st to 8th received bits go to data register 1 at bit positions 0 to 7, and the 9th to 16th go to data register 2 at positions 0 to 7. Bit 7 of each byte is the parity bit and is stored exactly as received, whether the parity is right or wrong.
- R5: Data bits are accepted only after a run-in of at least 6 consecutive bit transitions on the selected line. A run-in with 5 transitions leaves both registers at 00h.
- R6: After the run-in, data starts only after the three bits 0, 0, 1 in that order. Without that pattern both registers stay 00h.
- R7: While the enable input is low, nothing is cleared, nothing is captured and no interrupt is raised.
- R8: When the selected line ends, at the next line pulse or at a field pulse, `irq_o` is high for exactly one cycle if `irq_en_i` is set, and `pend_o` becomes 1.
- R9: With `irq_en_i` low, the end of the selected line produces no interrupt and does not set the pending flag.
- R10: Writing 0 to the pending flag clears it and writing 1 does nothing. If a set and a clear fall in the same cycle, the set wins.
- R11: Bits received after the sixteenth data bit of a line are ignored, even if they contain the start pattern.
- R12: The line count does not wrap. Once it has passed line 31, no later line in the field matches the line-select register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Acquisition enable |
| irq_en_i | input | 1 | End-of-line interrupt enable |
| sel_wr_i | input | 1 | Write strobe for the line-select register |
| sel_wdata_i | input | 5 | New line-select value |
| pend_wr_i | input | 1 | Write strobe for the pending flag |
| pend_wdata_i | input | 1 | Value written to the pending flag (only 0 has an effect) |
| field_start_i | input | 1 | One-cycle pulse at the start of a field |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| bit_vld_i | input | 1 | Strobe marking one sliced bit |
| bit_i | input | 1 | Sliced NRZ bit value |
| sel_o | output | 5 | Current line-select value |
| data1_o | output | 8 | First caption byte |
| data2_o | output | 8 | Second caption byte |
| irq_o | output | 1 | One-cycle end-of-line interrupt |
| pend_o | output | 1 | Pending interrupt flag |

## Verification
The main function is swept over all 128 character values of the first byte. Each has a correct parity bit, and the second byte is derived from it, so any swap of the two bytes or any mistake in bit order or position shows up. The capture line is swept from 1 to 31 with full caption waveforms on the neighbouring lines, which exposes an off-by-one in the line count. Further patterns include a short run-in, a wrong start pattern, trailing bits that contain the start pattern, a byte with wrong parity, and a field long enough for the count to wrap. Together these separate the synchronisation conditions from plain bit shifting and show that parity is stored rather than checked.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_BYTES  = 2;
  localparam int N_BITS   = BYTE_W * N_BYTES;
  localparam int IDX_W    = $clog2(N_BITS);
  localparam int BIT_IW   = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    SYNC_HUNT = 2'd0,
    SYNC_DATA = 2'd1,
    SYNC_DONE = 2'd2
  } sync_state_e;
endpackage

// File: rtl/cc_line_track.sv
module cc_line_track #(
  parameter int LINE_W   = 5,
  parameter int DEF_LINE = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              irq_en_i,
  input  logic              sel_wr_i,
  input  logic [LINE_W-1:0] sel_wdata_i,
  input  logic              pend_wr_i,
  input  logic              pend_wdata_i,
  input  logic              field_start_i,
  input  logic              line_start_i,
  output logic [LINE_W-1:0] sel_o,
  output logic              open_o,
  output logic              active_o,
  output logic              irq_o,
  output logic              pend_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] cnt_q, cnt_nx, sel_q;
  logic              past_q, active_q, irq_q, pend_q;
  logic              line_hit, line_end;

  always_comb begin
    cnt_nx   = cnt_q + 1'b1;
    line_hit = !past_q && (cnt_q != LINE_MAX) && (cnt_nx == sel_q);
    open_o   = line_start_i && !field_start_i && en_i && line_hit;
    line_end = (line_start_i || field_start_i) && active_q && en_i;
  end

  // line counter; past_q marks lines beyond the counter range
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      past_q <= 1'b0;
    end else if (field_start_i) begin
      cnt_q  <= '0;
      past_q <= 1'b0;
    end else if (line_start_i) begin
      if (cnt_q == LINE_MAX) past_q <= 1'b1;
      else                   cnt_q  <= cnt_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= LINE_W'(DEF_LINE);
      active_q <= 1'b0;
      irq_q    <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (sel_wr_i) sel_q <= sel_wdata_i;
      if (open_o)                              active_q <= 1'b1;
      else if (line_start_i || field_start_i)  active_q <= 1'b0;
      irq_q <= line_end && irq_en_i;
      if (line_end && irq_en_i)              pend_q <= 1'b1;
      else if (pend_wr_i && !pend_wdata_i)   pend_q <= 1'b0;
    end
  end

  assign sel_o    = sel_q;
  assign active_o = active_q;
  assign irq_o    = irq_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/cc_bit_sync.sv
module cc_bit_sync
  import cc_pkg::*;
#(
  parameter int RUNIN_EDGES = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             bit_ok_i,
  input  logic             bit_i,
  output logic             dvld_o,
  output logic [IDX_W-1:0] didx_o
);
  localparam int CW = $clog2(RUNIN_EDGES + 1);
  localparam logic [CW-1:0]    EDGE_LAST = CW'(RUNIN_EDGES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_BITS - 1);

  sync_state_e      state_q;
  logic [1:0]       hist_q;
  logic             have_prev_q, runin_ok_q;
  logic [CW-1:0]    edge_q;
  logic [IDX_W-1:0] idx_q;

  assign dvld_o = bit_ok_i && (state_q == SYNC_DATA);
  assign didx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= SYNC_DONE;
      hist_q      <= 2'b11;
      have_prev_q <= 1'b0;
      runin_ok_q  <= 1'b0;
      edge_q      <= '0;
      idx_q       <= '0;
    end else if (restart_i) begin
      state_q     <= SYNC_HUNT;
      hist_q      <= 2'b11;
      have_prev_q <= 1'b0;
      runin_ok_q  <= 1'b0;
      edge_q      <= '0;
      idx_q       <= '0;
    end else if (bit_ok_i) begin
      hist_q      <= {hist_q[0], bit_i};
      have_prev_q <= 1'b1;
      // run-in: consecutive transitions, sticky once long enough
      if (have_prev_q && (bit_i != hist_q[0])) begin
        if (edge_q != EDGE_LAST + 1'b1) edge_q <= edge_q + 1'b1;
        if (edge_q == EDGE_LAST) runin_ok_q <= 1'b1;
      end else begin
        edge_q <= '0;
      end
      case (state_q)
        SYNC_HUNT:
          if (runin_ok_q && hist_q == 2'b00 && bit_i) state_q <= SYNC_DATA;
        SYNC_DATA: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_LAST) state_q <= SYNC_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cc_byte_store.sv
module cc_byte_store
  import cc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             dvld_i,
  input  logic [IDX_W-1:0] didx_i,
  input  logic             bit_i,
  output logic [N_BYTES-1:0][BYTE_W-1:0] data_o
);
  localparam int BSW = IDX_W - BIT_IW;

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        q <= '0;
      else if (clr_i)
        q <= '0;
      else if (dvld_i && didx_i[IDX_W-1:BIT_IW] == BSW'(g))
        q[didx_i[BIT_IW-1:0]] <= bit_i;
    end
    assign data_o[g] = q;
  end
endmodule

// File: rtl/cc_acq.sv
module cc_acq
  import cc_pkg::*;
#(
  parameter int LINE_W      = 5,
  parameter int DEF_LINE    = 21,
  parameter int RUNIN_EDGES = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              irq_en_i,
  input  logic              sel_wr_i,
  input  logic [LINE_W-1:0] sel_wdata_i,
  input  logic              pend_wr_i,
  input  logic              pend_wdata_i,
  input  logic              field_start_i,
  input  logic              line_start_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic [LINE_W-1:0] sel_o,
  output logic [BYTE_W-1:0] data1_o,
  output logic [BYTE_W-1:0] data2_o,
  output logic              irq_o,
  output logic              pend_o
);
  logic             open, active, bit_ok, dvld;
  logic [IDX_W-1:0] didx;
  logic [N_BYTES-1:0][BYTE_W-1:0] data;

  cc_line_track #(.LINE_W(LINE_W), .DEF_LINE(DEF_LINE)) u_track (
    .clk_i, .rst_ni, .en_i, .irq_en_i, .sel_wr_i, .sel_wdata_i,
    .pend_wr_i, .pend_wdata_i, .field_start_i, .line_start_i,
    .sel_o, .open_o(open), .active_o(active), .irq_o, .pend_o
  );

  assign bit_ok = bit_vld_i && en_i && active && !line_start_i && !field_start_i;

  cc_bit_sync #(.RUNIN_EDGES(RUNIN_EDGES)) u_sync (
    .clk_i, .rst_ni, .restart_i(open), .bit_ok_i(bit_ok), .bit_i,
    .dvld_o(dvld), .didx_o(didx)
  );

  cc_byte_store u_store (
    .clk_i, .rst_ni, .clr_i(open), .dvld_i(dvld), .didx_i(didx), .bit_i,
    .data_o(data)
  );

  assign data1_o = data[0];
  assign data2_o = data[1];
endmodule

// File: rtl/cc_acq_chk.sv
module cc_acq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       irq_en_i,
  input logic       pend_wr_i,
  input logic       pend_wdata_i,
  input logic       open,
  input logic [7:0] data1_o,
  input logic [7:0] data2_o,
  input logic       irq_o,
  input logic       pend_o
);
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open |=> (data1_o == 8'h00 && data2_o == 8'h00));
  p_hold_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(data1_o) && $stable(data2_o) && !irq_o));
  p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_irq_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o);
  p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i));
  p_pend_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_o) |-> $past(pend_wr_i && !pend_wdata_i));
endmodule

bind cc_acq cc_acq_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .irq_en_i(irq_en_i),
  .pend_wr_i(pend_wr_i), .pend_wdata_i(pend_wdata_i), .open(open),
  .data1_o(data1_o), .data2_o(data2_o), .irq_o(irq_o), .pend_o(pend_o)
);

// File: tb/test_cc_acq.sv
module test_cc_acq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, ie = 1'b0, sel_wr = 1'b0, pend_wr = 1'b0, pend_wd = 1'b0;
  logic [4:0] sel_wd = '0;
  logic fs = 1'b0, ls = 1'b0, bv = 1'b0, b = 1'b0;
  logic [4:0] sel_o;
  logic [7:0] d1, d2;
  logic irq, pend;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit clr_on_end = 0;

  always #4 clk = ~clk;

  cc_acq i_cc_acq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .irq_en_i(ie),
    .sel_wr_i(sel_wr), .sel_wdata_i(sel_wd), .pend_wr_i(pend_wr),
    .pend_wdata_i(pend_wd), .field_start_i(fs), .line_start_i(ls),
    .bit_vld_i(bv), .bit_i(b), .sel_o(sel_o), .data1_o(d1), .data2_o(d2),
    .irq_o(irq), .pend_o(pend)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] with_par(input logic [6:0] c);
    return {~^c, c};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_ls();
    ls = 1'b1;
    if (clr_on_end) begin pend_wr = 1'b1; pend_wd = 1'b0; end
    tick();
    ls = 1'b0; pend_wr = 1'b0;
  endtask

  task automatic send_bit(input logic v);
    bv = 1'b1; b = v; tick(); bv = 1'b0;
  endtask

  task automatic send_cc(input int edges, input logic [2:0] st, input logic [15:0] pay, input int extra);
    for (int i = 0; i <= edges; i++) send_bit(~i[0]);
    send_bit(st[2]); send_bit(st[1]); send_bit(st[0]);
    for (int i = 0; i < 16; i++) send_bit(pay[i]);
    for (int i = 0; i < extra; i++) send_bit(i % 3 == 2);
    tick();
  endtask

  // one field: lines 1..last, caption waveform on line sel, decoys around it
  task automatic cc_field(input int sel, input int last, input int edges, input logic [2:0] st,
                          input logic [15:0] pay, input int extra, input logic [15:0] exp,
                          input logic exp_irq, input string tag);
    fs = 1'b1; tick(); fs = 1'b0;
    for (int n = 1; n <= last; n++) begin
      pulse_ls();
      if (n == sel) begin
        if (en) check({"R3 clear ", tag}, {d2, d1}, 16'h0000);
        send_cc(edges, st, pay, extra);
      end else begin
        if (n == sel + 1) begin
          check({"R8 irq ", tag}, {15'd0, irq}, {15'd0, exp_irq});
          tick();
          check({"R8 pulse ", tag}, {15'd0, irq}, 16'd0);
        end
        if (n == sel - 1 || n == sel + 1 || n == 33) send_cc(6, 3'b001, 16'h5AC3 ^ pay, 0);
        else tick();
      end
    end
    check({"R4 data ", tag}, {d2, d1}, exp);
  endtask

  task automatic wr_sel(input logic [4:0] v);
    sel_wr = 1'b1; sel_wd = v; tick(); sel_wr = 1'b0;
  endtask

  task automatic wr_pend(input logic v);
    pend_wr = 1'b1; pend_wd = v; tick(); pend_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] p;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 sel default", {11'd0, sel_o}, 16'd21);
    check("R1 data", {d2, d1}, 16'h0000);
    check("R1 irq/pend", {14'd0, irq, pend}, 16'd0);

    en = 1'b1; ie = 1'b1;
    // R4: every 7-bit character in byte 1, derived character in byte 2
    for (int c = 0; c < 128; c++) begin
      p = {with_par(7'(c) ^ 7'h2B), with_par(7'(c))};
      cc_field(21, 22, 6, 3'b001, p, 0, p, 1'b1, "R4 sweep");
    end
    check("R8 pend set", {15'd0, pend}, 16'd1);
    wr_pend(1'b1);
    check("R10 write 1 keeps", {15'd0, pend}, 16'd1);
    wr_pend(1'b0);
    check("R10 write 0 clears", {15'd0, pend}, 16'd0);

    // R2: capture line sweep with decoys on the neighbours
    for (int s = 1; s < 32; s++) begin
      wr_sel(5'(s));
      check("R2 sel write", {11'd0, sel_o}, 16'(s));
      p = {with_par(7'(s)), with_par(7'(s * 3 + 1))};
      cc_field(s, s + 1, 6, 3'b001, p, 0, p, 1'b1, "R2 line sweep");
    end

    // R12: count passes 31, line 33 must not alias line 1
    wr_sel(5'd1);
    p = 16'h1234;
    cc_field(1, 34, 6, 3'b001, p, 0, p, 1'b1, "R12 no wrap");

    wr_sel(5'd21);
    // R4 parity stored as received (wrong parity on both bytes)
    p = {~with_par(7'h41) & 8'hFF ^ 8'h7F, with_par(7'h03) ^ 8'h80};
    cc_field(21, 22, 6, 3'b001, p, 0, p, 1'b1, "R4 bad parity");
    // R5 short run-in
    cc_field(21, 22, 5, 3'b001, 16'hFFFF, 0, 16'h0000, 1'b1, "R5 short run-in");
    // R6 wrong start pattern
    cc_field(21, 22, 6, 3'b011, 16'hFFFF, 0, 16'h0000, 1'b1, "R6 bad start");
    // R11 trailing bits with start pattern inside
    p = 16'hC3A5;
    cc_field(21, 22, 6, 3'b001, p, 9, p, 1'b1, "R11 trailing bits");

    // R8 end of line by field pulse
    cc_field(21, 21, 6, 3'b001, 16'h0F0F, 0, 16'h0F0F, 1'b0, "R8 last line");
    fs = 1'b1; tick(); fs = 1'b0;
    check("R8 irq at field pulse", {15'd0, irq}, 16'd1);
    tick();
    check("R8 irq one cycle", {15'd0, irq}, 16'd0);

    // R10 set wins over simultaneous clear
    wr_pend(1'b0);
    clr_on_end = 1;
    cc_field(21, 22, 6, 3'b001, 16'h7777, 0, 16'h7777, 1'b1, "R10 set wins");
    clr_on_end = 0;
    check("R10 set wins", {15'd0, pend}, 16'd1);
    wr_pend(1'b0);

    // R9 interrupt disabled: capture still works, no irq, no pend
    ie = 1'b0;
    cc_field(21, 22, 6, 3'b001, 16'h2468, 0, 16'h2468, 1'b0, "R9 irq off");
    check("R9 pend stays", {15'd0, pend}, 16'd0);

    // R7 acquisition disabled: previous bytes kept
    en = 1'b0; ie = 1'b1;
    cc_field(21, 22, 6, 3'b001, 16'h9999, 0, 16'h2468, 1'b0, "R7 disabled");
    check("R7 pend stays", {15'd0, pend}, 16'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule